// File: doc/BRIEF.md
# Reed-Solomon Symbol Error Patcher

This block repairs a 512-byte chunk sitting in an external byte-wide RAM, using the results of a Reed-Solomon decoder. The decoder counts 9-bit symbols laid end to end through the byte stream. It returns three things: a flag that says errors were seen, a flag that says they cannot be corrected, and an error count. For each error it also gives a symbol index and a 9-bit mask. One pulse on `start` captures all of these. The block then patches the RAM with one read-modify-write per usable error.

For symbol index k, the block works out a byte position i and a bit offset j. Bytes i and i-1 form a 16-bit window, with byte i in the upper half. The mask is XORed into the window starting at bit j, and both bytes are written back. Two end-of-buffer cases need care. An index that lands past the chunk is dropped. An index that lands exactly on the chunk end touches only the last byte. When the run finishes, the block pulses `done`. If the decoder said the errors cannot be corrected, it pulses `fail` and leaves the RAM alone.

The RAM port is synchronous: data read at one clock edge appears on `memRdata` in the following cycle. A write takes place at the clock edge where `memWe` is high.

Top module: `rs_symbol_patcher`

## Requirements
- R1: For a symbol index k, let p = 9k. Then i = p>>3 and j = p&7, except that when p&7 is 0 the result is i = (p>>3)-1 and j = 7. Otherwise j = (p&7)-1.
- R2: For an applied report, the new pair {byte i, byte i-1} equals the old pair XOR (mask << j). Byte i-1 is written first, then byte i.
- R3: A report whose i is above 512, or whose index is 0, is skipped. It causes no RAM read or write and changes no byte.
- R4: A report whose i equals 512 reads and writes only byte 511. The mask bits that fall above bit 7 of the window are dropped.
- R5: `errCount` is a 3-bit binary count. Report r takes its index from `symIdx[r*10 +: 10]` and its mask from `symMask[r*9 +: 9]`. Reports errCount-1 down to 0 are applied in that order, and higher-numbered reports are ignored.
- R6: If `uncorrectable` is high at start, `fail` pulses for one cycle in the cycle right after the start edge. The RAM is not accessed and `done` stays low.
- R7: If `errFlag` is low at start, or `errCount` is 0 or greater than 4, `done` pulses in the cycle right after the start edge and the RAM is not accessed.
- R8: After the start edge, an applied report takes 5 cycles, or 6 when byte i exists, and a skipped report takes 1 cycle. `done` is high for exactly one cycle, in the cycle after the last write.
- R9: A `start` pulse that arrives while a run is in progress is ignored.
- R10: During reset, `done`, `fail`, `memRe` and `memWe` are all low.
- R11: Each applied report reads byte i-1, then byte i (when it exists), then writes the bytes back. A write strobe never starts unless a read was issued three cycles earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Captures the decoder results and begins a run |
| errFlag | input | 1 | Decoder saw errors |
| uncorrectable | input | 1 | Errors are beyond repair |
| errCount | input | 3 | Number of error reports, 1 to 4 valid |
| symIdx | input | 40 | Four 10-bit symbol indices |
| symMask | input | 36 | Four 9-bit error masks |
| memAddr | output | 9 | RAM byte address |
| memRe | output | 1 | RAM read strobe |
| memWe | output | 1 | RAM write strobe |
| memWdata | output | 8 | RAM write data |
| memRdata | input | 8 | RAM read data, one cycle after the read |
| done | output | 1 | Run finished, one-cycle pulse |
| fail | output | 1 | Uncorrectable error, one-cycle pulse |

## Verification
The bench aims at the aligned-offset case, where p&7 is 0. A design that skips the remap would shift the mask one bit too far and damage the wrong byte pair. It drives the indices that land on byte 511 with a high byte present, exactly on the chunk end, and past it. Off-by-one handling of the end would write address 0, because the address wraps, or corrupt the final byte. It gives a count smaller than the number of filled reports and checks the order of the write addresses, which exposes wrong report ordering and stale reports being applied. Repeated indices, an uncorrectable flag, an illegal count, and a start pulse during a run show up as wrong data, a wrong `done`/`fail` cycle, or stray writes.

// File: rtl/rs_patch_pkg.sv
package rs_patch_pkg;
  localparam int SYM_BITS    = 9;
  localparam int MAX_REPORTS = 4;
  localparam int RPT_SEL_W   = $clog2(MAX_REPORTS);
  localparam int CNT_W       = RPT_SEL_W + 1;
  localparam int WIN_W       = 16;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CALC, ST_RDLO, ST_RDHI, ST_MERGE, ST_WRLO, ST_WRHI, ST_DONE, ST_FAIL
  } patchState_t;

  typedef struct packed {
    logic                 latchIn;
    logic                 loadCur;
    logic                 capLo;
    logic                 doMerge;
    logic                 addrHi;
    logic [RPT_SEL_W-1:0] rptSel;
  } dpCtl_t;
endpackage

// File: rtl/rs_patch_dp.sv
module rs_patch_dp
  import rs_patch_pkg::*;
#(
  parameter int CHUNK_BYTES = 512,
  parameter int IDX_W       = 10,
  parameter int ADDR_W      = $clog2(CHUNK_BYTES)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  dpCtl_t                         ctl,
  input  logic [MAX_REPORTS*IDX_W-1:0]   symIdx,
  input  logic [MAX_REPORTS*SYM_BITS-1:0] symMask,
  input  logic [7:0]                     memRdata,
  output logic [ADDR_W-1:0]              memAddr,
  output logic [7:0]                     memWdata,
  output logic                           skipNow,
  output logic                           hasHi
);
  localparam int POS_W  = IDX_W + 4;
  localparam int BYTE_W = POS_W - 3;

  logic [IDX_W-1:0]    idxHold  [MAX_REPORTS];
  logic [SYM_BITS-1:0] maskHold [MAX_REPORTS];

  for (genvar r = 0; r < MAX_REPORTS; r++) begin : gHold
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        idxHold[r]  <= '0;
        maskHold[r] <= '0;
      end else if (ctl.latchIn) begin
        idxHold[r]  <= symIdx[r*IDX_W +: IDX_W];
        maskHold[r] <= symMask[r*SYM_BITS +: SYM_BITS];
      end
    end
  end

  // index to byte/bit position
  logic [IDX_W-1:0]  selIdx;
  logic [POS_W-1:0]  prod;
  logic [BYTE_W-1:0] rawByte, calcByte;
  logic [2:0]        calcBit;

  always_comb begin
    selIdx   = idxHold[ctl.rptSel];
    prod     = POS_W'(selIdx) * POS_W'(SYM_BITS);
    rawByte  = prod[POS_W-1:3];
    calcByte = (prod[2:0] == 3'd0) ? rawByte - BYTE_W'(1) : rawByte;
    calcBit  = (prod[2:0] == 3'd0) ? 3'd7 : prod[2:0] - 3'd1;
    skipNow  = (selIdx == '0) || (calcByte > BYTE_W'(CHUNK_BYTES));
  end

  logic [BYTE_W-1:0]   curByte;
  logic [2:0]          curBit;
  logic [SYM_BITS-1:0] curMask;
  logic                curHasHi;
  logic [7:0]          loReg;
  logic [WIN_W-1:0]    winReg;
  logic [WIN_W-1:0]    shifted;
  logic [7:0]          hiByte;

  assign shifted = WIN_W'(curMask) << curBit;
  assign hiByte  = curHasHi ? memRdata : 8'h00;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curByte  <= '0;
      curBit   <= '0;
      curMask  <= '0;
      curHasHi <= 1'b0;
      loReg    <= '0;
      winReg   <= '0;
    end else begin
      if (ctl.loadCur) begin
        curByte  <= calcByte;
        curBit   <= calcBit;
        curMask  <= maskHold[ctl.rptSel];
        curHasHi <= calcByte < BYTE_W'(CHUNK_BYTES);
      end
      if (ctl.capLo)   loReg  <= memRdata;
      if (ctl.doMerge) winReg <= {hiByte, loReg} ^ shifted;
    end
  end

  assign hasHi    = curHasHi;
  assign memAddr  = ctl.addrHi ? ADDR_W'(curByte) : ADDR_W'(curByte - BYTE_W'(1));
  assign memWdata = ctl.addrHi ? winReg[15:8] : winReg[7:0];

  AST_END_LO_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    ctl.addrHi |-> curHasHi); // R4
endmodule

// File: rtl/rs_patch_ctrl.sv
module rs_patch_ctrl
  import rs_patch_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             errFlag,
  input  logic             uncorrectable,
  input  logic [CNT_W-1:0] errCount,
  input  logic             skipNow,
  input  logic             hasHi,
  output dpCtl_t           ctl,
  output logic             memRe,
  output logic             memWe,
  output logic             done,
  output logic             fail
);
  patchState_t state, nextState;
  logic [RPT_SEL_W-1:0] cnt;
  logic cntLoad, cntDec, countOk;

  assign countOk = (errCount != '0) && (errCount <= CNT_W'(MAX_REPORTS));

  always_comb begin
    nextState   = state;
    ctl         = '0;
    ctl.rptSel  = cnt;
    memRe       = 1'b0;
    memWe       = 1'b0;
    cntLoad     = 1'b0;
    cntDec      = 1'b0;
    unique case (state)
      ST_IDLE: if (start) begin
        ctl.latchIn = 1'b1;
        if (uncorrectable)           nextState = ST_FAIL;
        else if (!errFlag || !countOk) nextState = ST_DONE;
        else begin
          cntLoad   = 1'b1;
          nextState = ST_CALC;
        end
      end
      ST_CALC: begin
        ctl.loadCur = 1'b1;
        if (!skipNow)        nextState = ST_RDLO;
        else if (cnt == '0)  nextState = ST_DONE;
        else begin
          cntDec    = 1'b1;
          nextState = ST_CALC;
        end
      end
      ST_RDLO: begin
        memRe     = 1'b1;
        nextState = ST_RDHI;
      end
      ST_RDHI: begin
        memRe      = hasHi;
        ctl.addrHi = hasHi;
        ctl.capLo  = 1'b1;
        nextState  = ST_MERGE;
      end
      ST_MERGE: begin
        ctl.doMerge = 1'b1;
        nextState   = ST_WRLO;
      end
      ST_WRLO, ST_WRHI: begin
        memWe      = 1'b1;
        ctl.addrHi = (state == ST_WRHI);
        if (state == ST_WRLO && hasHi) nextState = ST_WRHI;
        else if (cnt == '0)            nextState = ST_DONE;
        else begin
          cntDec    = 1'b1;
          nextState = ST_CALC;
        end
      end
      ST_DONE, ST_FAIL: nextState = ST_IDLE;
      default:          nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nextState;
      if (cntLoad)     cnt <= RPT_SEL_W'(errCount - CNT_W'(1));
      else if (cntDec) cnt <= cnt - RPT_SEL_W'(1);
    end
  end

  assign done = (state == ST_DONE);
  assign fail = (state == ST_FAIL);

  AST_RMW_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWe) |-> $past(memRe, 3)); // R11
  AST_FAIL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    fail |-> (!$past(memWe) && !$past(memRe))); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8
  AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CALC && skipNow) |=> (!memRe && !memWe)); // R3
endmodule

// File: rtl/rs_symbol_patcher.sv
module rs_symbol_patcher
  import rs_patch_pkg::*;
#(
  parameter int CHUNK_BYTES = 512,
  parameter int IDX_W       = 10,
  localparam int ADDR_W     = $clog2(CHUNK_BYTES)
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            start,
  input  logic                            errFlag,
  input  logic                            uncorrectable,
  input  logic [CNT_W-1:0]                errCount,
  input  logic [MAX_REPORTS*IDX_W-1:0]    symIdx,
  input  logic [MAX_REPORTS*SYM_BITS-1:0] symMask,
  output logic [ADDR_W-1:0]               memAddr,
  output logic                            memRe,
  output logic                            memWe,
  output logic [7:0]                      memWdata,
  input  logic [7:0]                      memRdata,
  output logic                            done,
  output logic                            fail
);
  dpCtl_t ctl;
  logic   skipNow, hasHi;

  rs_patch_ctrl ctrl_i (
    .clk, .rstN, .start, .errFlag, .uncorrectable, .errCount,
    .skipNow, .hasHi, .ctl, .memRe, .memWe, .done, .fail
  );

  rs_patch_dp #(.CHUNK_BYTES(CHUNK_BYTES), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) dp_i (
    .clk, .rstN, .ctl, .symIdx, .symMask, .memRdata,
    .memAddr, .memWdata, .skipNow, .hasHi
  );

  AST_IDLE_IN_RESET: assert property (@(posedge clk)
    !rstN |-> (!done && !fail && !memRe && !memWe)); // R10
endmodule

// File: tb/rs_symbol_patcher_tb.sv
module rs_symbol_patcher_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 512;

  logic clk = 1'b0, rstN = 1'b0;
  logic start = 1'b0, errFlag = 1'b0, uncorrectable = 1'b0;
  logic [2:0]  errCount = '0;
  logic [39:0] symIdx = '0;
  logic [35:0] symMask = '0;
  logic [8:0]  memAddr;
  logic        memRe, memWe, done, fail;
  logic [7:0]  memWdata, memRdata;

  int checks = 0, failures = 0;
  logic [7:0] ram [NB];
  int refMem [NB];
  int expAddrQ [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rs_symbol_patcher dut_i (
    .clk, .rstN, .start, .errFlag, .uncorrectable, .errCount, .symIdx, .symMask,
    .memAddr, .memRe, .memWe, .memWdata, .memRdata, .done, .fail
  );

  always @(posedge clk) begin
    if (memRe) memRdata <= ram[memAddr];
    if (memWe) ram[memAddr] <= memWdata;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // write address order monitor (R5, R11)
  always @(negedge clk) begin
    if (rstN && memWe) begin
      if (expAddrQ.size() == 0) check(0, "R3 stray write", memAddr, -1);
      else begin
        int e;
        e = expAddrQ.pop_front();
        check(memAddr == e, "R5 write order", memAddr, e);
      end
    end
  end

  // returns added cycles; updates reference image and write queue
  function automatic int modelReport(input int k, input int m);
    int p, i, j, d;
    p = 9 * k; i = p >> 3; j = p & 7;
    if (j == 0) begin i = i - 1; j = 7; end else j = j - 1;
    if (k == 0 || i > NB) return 1;
    d = (i < NB) ? ((refMem[i] << 8) | refMem[i-1]) : refMem[i-1];
    d = d ^ (m << j);
    refMem[i-1] = d & 255;
    expAddrQ.push_back(i - 1);
    if (i < NB) begin
      refMem[i] = (d >> 8) & 255;
      expAddrQ.push_back(i);
      return 6;
    end
    return 5;
  endfunction

  task automatic runOp(input bit flg, input bit unc, input int cnt,
                       input int k0, input int k1, input int k2, input int k3,
                       input int m0, input int m1, input int m2, input int m3,
                       input bit poke, input string tag);
    int ks[4], ms[4], dly, bad;
    ks = '{k0, k1, k2, k3}; ms = '{m0, m1, m2, m3};
    dly = 0;
    if (!unc && flg && cnt >= 1 && cnt <= 4)
      for (int r = cnt - 1; r >= 0; r--) dly += modelReport(ks[r], ms[r]);
    @(negedge clk);
    errFlag = flg; uncorrectable = unc; errCount = 3'(cnt);
    for (int r = 0; r < 4; r++) begin
      symIdx[r*10 +: 10] = 10'(ks[r]);
      symMask[r*9 +: 9]  = 9'(ms[r]);
    end
    start = 1'b1;
    @(posedge clk);
    for (int c = 0; c <= dly + 2; c++) begin
      @(negedge clk);
      start = (poke && c == 1);
      if (poke && c == 1) uncorrectable = 1'b1;
      if (c == 2) uncorrectable = 1'b0;
      check(done == (!unc && c == dly), {tag, " R8 done timing"}, done, (!unc && c == dly));
      check(fail == (unc && c == 0), {tag, " R6 fail timing"}, fail, (unc && c == 0));
    end
    start = 1'b0;
    bad = 0;
    for (int a = 0; a < NB; a++) if (ram[a] != 8'(refMem[a])) bad++;
    check(bad == 0, {tag, " R2 chunk contents"}, bad, 0);
    check(expAddrQ.size() == 0, {tag, " R11 missing writes"}, expAddrQ.size(), 0);
    expAddrQ.delete();
  endtask

  initial begin
    for (int a = 0; a < NB; a++) begin
      refMem[a] = (a * 37 + 5) & 255;
      ram[a] = 8'(refMem[a]);
    end
    repeat (3) @(negedge clk);
    check(!done && !fail && !memRe && !memWe, "R10 reset quiet", {done, fail, memRe, memWe}, 0);
    rstN = 1'b1;
    // R1/R2 basic, offset j=0 after remap
    runOp(1, 0, 1, 1, 0, 0, 0, 9'h1FF, 0, 0, 0, 0, "single k1");
    runOp(1, 0, 1, 8, 0, 0, 0, 9'h0A5, 0, 0, 0, 0, "R1 aligned k8");
    // R5 four reports, order high to low
    runOp(1, 0, 4, 3, 100, 200, 300, 9'h101, 9'h0F0, 9'h155, 9'h0AA, 0, "R5 four");
    // R5 count 2 with filled upper reports
    runOp(1, 0, 2, 50, 51, 400, 401, 9'h1C3, 9'h03C, 9'h1FF, 9'h1FF, 0, "R5 partial");
    // R4 end cases, R3 skips
    runOp(1, 0, 4, 455, 456, 457, 0, 9'h1E7, 9'h1FF, 9'h1FF, 9'h1FF, 0, "R4 R3 end");
    runOp(1, 0, 1, 1000, 0, 0, 0, 9'h1FF, 0, 0, 0, 0, "R3 far");
    // R2 repeated index cancels
    runOp(1, 0, 2, 77, 77, 0, 0, 9'h12D, 9'h12D, 0, 0, 0, "R2 repeat");
    // R6 uncorrectable
    runOp(1, 1, 2, 10, 20, 0, 0, 9'h1FF, 9'h1FF, 0, 0, 0, "R6 unc");
    // R7 no correction
    runOp(0, 0, 3, 10, 20, 30, 0, 9'h1FF, 9'h1FF, 9'h1FF, 0, 0, "R7 noflag");
    runOp(1, 0, 0, 10, 0, 0, 0, 9'h1FF, 0, 0, 0, 0, "R7 zero");
    runOp(1, 0, 5, 10, 20, 30, 40, 9'h1FF, 9'h1FF, 9'h1FF, 9'h1FF, 0, "R7 five");
    // R9 start while busy
    runOp(1, 0, 2, 60, 61, 0, 0, 9'h0F1, 9'h10E, 0, 0, 1, "R9 busy");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule